// File: doc/BRIEF.md
# I2C Target Mailbox Bridge

The bridge lets an external I2C master and an on-chip processor trade bytes through two one-way mailboxes behind a single 7-bit target address. Bytes the master writes land in an inbound bank. Each stored byte raises an interrupt line that stays inside the chip. The local processor answers through a three-byte outbound bank. Writing outbound byte 0 raises an attention output toward the master. The master then reads the outbound bank over I2C. Once the master has clocked out byte 0, the attention output drops.

Everything runs on one system clock (48 MHz in the target system). That clock oversamples SCL and SDA. Each pin passes through a two-flop synchroniser and a glitch filter that needs `FILT_LEN` stable cycles. The block never drives SCL. It pulls SDA low, or releases it, through `sda_oe_o`. Inside a transaction, the first byte the master writes sets an 8-bit register pointer. The pointer advances after every data byte in either direction. A repeated START keeps the pointer, so the master can write a pointer and then read from it.

The serial engine has eight states. `ST_IDLE` waits for a START. A START in any state moves to `ST_ADDR`, and a STOP in any state moves to `ST_IDLE`. `ST_ADDR` shifts in the address byte. On the falling SCL edge after the eighth bit it goes to `ST_ADDR_ACK` if the address matches, and to `ST_IGNORE` if not. From `ST_ADDR_ACK`, the falling edge of the ACK clock moves to `ST_WR_BYTE` for a write and to `ST_RD_BYTE` for a read. `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits. `ST_WR_ACK` returns to `ST_WR_BYTE` when the ACK clock falls. `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits. `ST_RD_ACK` returns to `ST_RD_BYTE` on a master ACK and goes to `ST_IGNORE` on a master NACK. `ST_IGNORE` leaves SDA released until the next START or STOP.

Top module: `i2c_mbox_bridge`

## Requirements
- R1: The block never drives SCL. A value of 1 on `sda_oe_o` pulls SDA low and 0 releases it. `sda_oe_o` is 0 during reset and after every STOP, and it changes only while the filtered SCL is low.
- R2: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` clock cycles has no effect on any transaction.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START returns the engine to address reception and keeps the register pointer.
- R4: An address byte whose upper 7 bits equal `TARGET_ADDR` is ACKed. Bit 0 of the address byte selects a read when it is 1. A non-matching address gets a NACK, and SDA stays released until the next START or STOP.
- R5: In a write, the first byte after the address loads the pointer. Each later byte is ACKed, stored in inbound register `ptr` when `ptr < IN_REGS`, and then increments the pointer. A byte with `ptr >= IN_REGS` is ACKed and discarded.
- R6: `irq_o` is set by every data byte the master writes. The pointer byte does not set it. It is cleared by a local write of 1 to bit 0 of the control register. A set and a clear in the same cycle leave it set.
- R7: A read returns outbound register `ptr`, MSB first, and increments the pointer after each byte. Values of `ptr` of 3 or more return 0x00. After a master NACK the block releases SDA.
- R8: A local write to outbound register 0 sets `attn_o`. Local writes to outbound registers 1 and 2 leave it unchanged.
- R9: `attn_o` clears when the master has clocked out the eighth bit of outbound register 0. Reads that do not cover register 0 leave it set.
- R10: The local bus uses these addresses. 0 to 2 are the outbound registers, and they can be read back. 3 is the control register: a read returns `{6'b0, attn, irq}`, and a write with bit 0 set clears `irq_o`. 4 to `4+IN_REGS-1` are the inbound registers, and they are read-only. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the I2C pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock as seen on the pin |
| sda_i | input | 1 | I2C data as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| lb_we_i | input | 1 | Local bus write strobe |
| lb_addr_i | input | LB_AW | Local bus register address |
| lb_wdata_i | input | 8 | Local bus write data |
| lb_rdata_o | output | 8 | Local bus read data (combinational) |
| irq_o | output | 1 | Interrupt to the local processor for inbound data |
| attn_o | output | 1 | Attention line to the master for outbound data |

## Verification
The assertions assume that the master follows I2C timing. SDA changes only while SCL is low, except for START and STOP. No START or STOP arrives while the target holds SDA low. Each SCL phase lasts longer than the synchroniser and filter latency. If these held only loosely, the check that SDA changes with SCL low, and the transitions on START and STOP, could fire on a correct design. The bench master waits 16 clock cycles in each quarter of a bit, well above the roughly eight-cycle pin latency. It changes data only a quarter period after SCL falls. The only pulses it injects deliberately are two cycles long, shorter than the filter length, and they are the stimulus for R2.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } eng_state_t;

    localparam int OUT_REGS    = 3;
    localparam int CTRL_IDX    = 3;
    localparam int IN_BASE     = 4;
    localparam int IRQ_CLR_BIT = 0;

endpackage

// File: rtl/mbx_pin_filter.sv
module mbx_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            filt_o <= 1'b1;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            if (sync_q[1] != filt_o) begin
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    filt_o <= sync_q[1];
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // R2: the filtered level only moves after a full stable window
    a_r2_filter_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> $past(cnt_q) == CW'(FILT_LEN - 1));

endmodule

// File: rtl/mbx_i2c_engine.sv
module mbx_i2c_engine
    import mbox_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] out_byte,
    output logic       sda_oe,
    output logic [7:0] ptr,
    output logic       wr_stb,
    output logic [7:0] wr_data,
    output logic       rd_done
);
    eng_state_t state, nstate;
    logic       scl_q, sda_q;
    logic [3:0] bitcnt;
    logic [7:0] sh;
    logic       ptr_pend;
    logic       mnack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    logic ev_start, ev_stop, scl_rise, scl_fall;
    assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
    assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;

    // next-state logic
    always_comb begin
        nstate = state;
        if (ev_stop) begin
            nstate = ST_IDLE;
        end else if (ev_start) begin
            nstate = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR:
                    if (scl_fall && bitcnt == 4'd8)
                        nstate = (sh[7:1] == TARGET_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall) nstate = sh[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:
                    if (scl_fall && bitcnt == 4'd8) nstate = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall) nstate = ST_WR_BYTE;
                ST_RD_BYTE:
                    if (scl_fall && bitcnt == 4'd7) nstate = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall) nstate = mnack ? ST_IGNORE : ST_RD_BYTE;
                default: nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // strobes toward the register banks
    assign wr_stb  = (state == ST_WR_BYTE) && scl_fall && (bitcnt == 4'd8) && !ptr_pend;
    assign wr_data = sh;
    assign rd_done = (state == ST_RD_BYTE) && scl_fall && (bitcnt == 4'd7);

    // shift register, bit counter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            sh       <= '0;
            ptr      <= '0;
            ptr_pend <= 1'b0;
            mnack    <= 1'b0;
        end else if (ev_start || ev_stop) begin
            bitcnt <= '0;
            if (ev_start) ptr_pend <= 1'b1;
        end else begin
            unique case (state)
                ST_ADDR:
                    if (scl_rise) begin
                        sh     <= {sh[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end
                ST_ADDR_ACK:
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (sh[0]) sh <= out_byte;
                    end
                ST_WR_BYTE:
                    if (scl_rise) begin
                        sh     <= {sh[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        if (ptr_pend) begin
                            ptr      <= sh;
                            ptr_pend <= 1'b0;
                        end else begin
                            ptr <= ptr + 8'd1;
                        end
                    end
                ST_WR_ACK:
                    if (scl_fall) bitcnt <= '0;
                ST_RD_BYTE:
                    if (scl_fall) begin
                        bitcnt <= bitcnt + 4'd1;
                        sh     <= {sh[6:0], 1'b0};
                        if (bitcnt == 4'd7) ptr <= ptr + 8'd1;
                    end
                ST_RD_ACK:
                    if (scl_rise) begin
                        mnack <= sda_f;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        sh     <= out_byte;
                    end
                default: ;
            endcase
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~sh[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    // R1: SDA is only moved while SCL is low
    a_r1_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R3: START enters address reception with a cleared bit count
    a_r3_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (state == ST_ADDR && bitcnt == 4'd0));

    // R3: STOP returns to idle
    a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (state == ST_IDLE));

    // R4: foreign address gives NACK and silence
    a_r4_foreign_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bitcnt == 4'd8 && sh[7:1] != TARGET_ADDR)
        |=> (state == ST_IGNORE && !sda_oe));

    // R5: pointer advances after every stored write byte
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ptr == $past(ptr) + 8'd1);

    // R7: pointer advances after every byte sent
    a_r7_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> ptr == $past(ptr) + 8'd1);

endmodule

// File: rtl/mbx_reg_banks.sv
module mbx_reg_banks
    import mbox_pkg::*;
#(
    parameter int IN_REGS = 4,
    parameter int LB_AW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lb_we,
    input  logic [LB_AW-1:0] lb_addr,
    input  logic [7:0]       lb_wdata,
    output logic [7:0]       lb_rdata,
    input  logic [7:0]       ptr,
    input  logic             wr_stb,
    input  logic [7:0]       wr_data,
    input  logic             rd_done,
    output logic [7:0]       out_byte,
    output logic             irq,
    output logic             attn
);
    logic [7:0] out_q [OUT_REGS];
    logic [7:0] in_q  [IN_REGS];

    logic ctrl_clr, out0_wr;
    assign ctrl_clr = lb_we && (lb_addr == LB_AW'(CTRL_IDX)) && lb_wdata[IRQ_CLR_BIT];
    assign out0_wr  = lb_we && (lb_addr == LB_AW'(0));

    for (genvar g = 0; g < OUT_REGS; g++) begin : g_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  out_q[g] <= '0;
            else if (lb_we && lb_addr == LB_AW'(g))      out_q[g] <= lb_wdata;
        end
    end

    for (genvar g = 0; g < IN_REGS; g++) begin : g_in
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  in_q[g] <= '0;
            else if (wr_stb && ptr == 8'(g))             in_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            attn <= 1'b0;
        end else begin
            if (wr_stb)        irq <= 1'b1;
            else if (ctrl_clr) irq <= 1'b0;
            if (out0_wr)                       attn <= 1'b1;
            else if (rd_done && ptr == 8'd0)   attn <= 1'b0;
        end
    end

    always_comb begin
        out_byte = 8'h00;
        for (int i = 0; i < OUT_REGS; i++)
            if (ptr == 8'(i)) out_byte = out_q[i];
    end

    always_comb begin
        lb_rdata = 8'h00;
        for (int i = 0; i < OUT_REGS; i++)
            if (lb_addr == LB_AW'(i)) lb_rdata = out_q[i];
        if (lb_addr == LB_AW'(CTRL_IDX)) lb_rdata = {6'b0, attn, irq};
        for (int j = 0; j < IN_REGS; j++)
            if (lb_addr == LB_AW'(IN_BASE + j)) lb_rdata = in_q[j];
    end

    // R6: a stored master byte always raises the interrupt
    a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> irq);

    // R6: a local clear without a concurrent set drops the interrupt
    a_r6_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_clr && !wr_stb) |=> !irq);

    // R8: writing outbound register 0 raises attention
    a_r8_attn_set: assert property (@(posedge clk) disable iff (!rst_n)
        out0_wr |=> attn);

    // R9: finishing the read of register 0 drops attention
    a_r9_attn_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && ptr == 8'd0 && !out0_wr) |=> !attn);

endmodule

// File: rtl/i2c_mbox_bridge.sv
module i2c_mbox_bridge
    import mbox_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h42,
    parameter int         IN_REGS     = 4,
    parameter int         FILT_LEN    = 4,
    localparam int        LB_AW       = $clog2(IN_BASE + IN_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic             lb_we_i,
    input  logic [LB_AW-1:0] lb_addr_i,
    input  logic [7:0]       lb_wdata_i,
    output logic [7:0]       lb_rdata_o,
    output logic             irq_o,
    output logic             attn_o
);
    localparam int PINS = 2;

    logic [PINS-1:0] pin_raw, pin_filt;
    assign pin_raw = {scl_i, sda_i};

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        mbx_pin_filter #(.FILT_LEN(FILT_LEN)) i_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_raw[g]),
            .filt_o (pin_filt[g])
        );
    end

    logic [7:0] ptr, wr_data, out_byte;
    logic       wr_stb, rd_done;

    mbx_i2c_engine #(.TARGET_ADDR(TARGET_ADDR)) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (pin_filt[1]),
        .sda_f    (pin_filt[0]),
        .out_byte (out_byte),
        .sda_oe   (sda_oe_o),
        .ptr      (ptr),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_done  (rd_done)
    );

    mbx_reg_banks #(.IN_REGS(IN_REGS), .LB_AW(LB_AW)) i_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .lb_we    (lb_we_i),
        .lb_addr  (lb_addr_i),
        .lb_wdata (lb_wdata_i),
        .lb_rdata (lb_rdata_o),
        .ptr      (ptr),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_done  (rd_done),
        .out_byte (out_byte),
        .irq      (irq_o),
        .attn     (attn_o)
    );

endmodule

// File: tb/test_i2c_mbox_bridge.sv
`timescale 1ns/1ps
module test_i2c_mbox_bridge;
    localparam logic [6:0] TADDR = 7'h42;
    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe;
    logic       lb_we = 1'b0;
    logic [2:0] lb_addr = '0;
    logic [7:0] lb_wdata = '0, lb_rdata;
    logic       irq, attn;
    wire        sda_bus = sda_m & ~sda_oe;

    int total = 0, bad = 0, oe_cnt = 0;
    logic [7:0] exp_in [4];
    logic [7:0] exp_out [3];

    always #2.5 clk = ~clk;
    always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

    i2c_mbox_bridge #(.TARGET_ADDR(TADDR), .IN_REGS(4), .FILT_LEN(4)) i_i2c_mbox_bridge (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .lb_we_i(lb_we), .lb_addr_i(lb_addr), .lb_wdata_i(lb_wdata), .lb_rdata_o(lb_rdata),
        .irq_o(irq), .attn_o(attn)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            if (glitch && b[i]) begin
                sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(Q - 2);
            end else begin
                tick(Q);
            end
            scl_m = 1'b0;
            if (glitch) begin
                tick(Q / 2); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q / 2 - 2);
            end else begin
                tick(Q);
            end
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_bus; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic lb_write(input logic [2:0] a, input logic [7:0] d);
        lb_addr = a; lb_wdata = d; lb_we = 1'b1; tick(1);
        lb_we = 1'b0; tick(1);
    endtask

    task automatic lb_read(input logic [2:0] a, output logic [7:0] d);
        lb_addr = a; #1; d = lb_rdata;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] rd, d;
        int snap;
        for (int j = 0; j < 4; j++) exp_in[j] = 8'h00;
        for (int j = 0; j < 3; j++) exp_out[j] = 8'h00;
        tick(5); rst_n = 1'b1; tick(5);

        // reset state
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R6 reset irq", irq, 0);
        chk("R8 reset attn", attn, 0);
        lb_read(3'd3, rd); chk("R10 reset ctrl", rd, 8'h00);

        // R5 write sweep over start pointers, including dropped bytes
        for (int p = 0; p < 6; p++) begin
            i2c_start();
            send_byte({TADDR, 1'b0}, 0, ack); chk("R4 address ack", ack, 1);
            send_byte(8'(p), 0, ack); chk("R5 pointer ack", ack, 1);
            for (int k = 0; k < 2; k++) begin
                d = 8'(p * 37 + k * 11 + 5);
                send_byte(d, 0, ack); chk("R5 data ack", ack, 1);
                if (p + k < 4) exp_in[p + k] = d;
            end
            i2c_stop();
            chk("R1 released after stop", sda_oe, 0);
            for (int j = 0; j < 4; j++) begin
                lb_read(3'(4 + j), rd); chk("R5 R10 inbound content", rd, exp_in[j]);
            end
            chk("R6 irq after write", irq, 1);
            lb_write(3'd3, 8'h01);
            chk("R6 irq cleared", irq, 0);
        end

        // R4 foreign address
        snap = oe_cnt;
        i2c_start();
        send_byte({7'h43, 1'b0}, 0, ack); chk("R4 foreign nack", ack, 0);
        send_byte(8'h00, 0, ack); chk("R4 no ack after foreign", ack, 0);
        send_byte(8'hAA, 0, ack);
        i2c_stop();
        chk("R4 never drove sda", oe_cnt - snap, 0);
        chk("R6 irq untouched by foreign", irq, 0);
        lb_read(3'd4, rd); chk("R4 inbound untouched", rd, exp_in[0]);

        // R6 pointer-only write does not interrupt
        i2c_start();
        send_byte({TADDR, 1'b0}, 0, ack);
        send_byte(8'h01, 0, ack);
        i2c_stop();
        chk("R6 pointer byte no irq", irq, 0);

        // R8 attention set only by register 0
        lb_write(3'd1, 8'hB1); exp_out[1] = 8'hB1;
        lb_write(3'd2, 8'hC2); exp_out[2] = 8'hC2;
        chk("R8 attn stays low", attn, 0);
        lb_write(3'd0, 8'hA0); exp_out[0] = 8'hA0;
        chk("R8 attn raised", attn, 1);
        for (int j = 0; j < 3; j++) begin
            lb_read(3'(j), rd); chk("R10 outbound readback", rd, exp_out[j]);
        end
        lb_read(3'd3, rd); chk("R10 ctrl shows attn", rd, 8'h02);

        // R7 read sweep with repeated start (R3)
        for (int p = 0; p < 5; p++) begin
            d = 8'hA0 + 8'(p);
            lb_write(3'd0, d); exp_out[0] = d;
            i2c_start();
            send_byte({TADDR, 1'b0}, 0, ack);
            send_byte(8'(p), 0, ack);
            chk("R9 attn before read", attn, 1);
            i2c_start();
            send_byte({TADDR, 1'b1}, 0, ack); chk("R3 R4 read address ack", ack, 1);
            for (int k = 0; k < 3; k++) begin
                recv_byte(k < 2, rd);
                chk("R7 read data", rd, (p + k < 3) ? exp_out[p + k] : 8'h00);
            end
            chk("R7 released after nack", sda_oe, 0);
            i2c_stop();
            chk("R9 attn after read", attn, (p == 0) ? 1'b0 : 1'b1);
        end

        // R2 glitches on SDA and SCL are ignored
        i2c_start();
        send_byte({TADDR, 1'b0}, 0, ack);
        send_byte(8'h02, 0, ack);
        send_byte(8'hB5, 1, ack); chk("R2 ack despite glitches", ack, 1);
        exp_in[2] = 8'hB5;
        send_byte(8'h6E, 0, ack);
        exp_in[3] = 8'h6E;
        i2c_stop();
        lb_read(3'd6, rd); chk("R2 glitched byte intact", rd, exp_in[2]);
        lb_read(3'd7, rd); chk("R2 next byte intact", rd, exp_in[3]);

        summary();
        $finish;
    end
endmodule